// File: doc/BRIEF.md
# Line-Doubling Scan Converter

This block takes a one-bit serial video stream at the slow line rate, together with its horizontal and vertical sync, and re-emits it at twice the line rate as 12-bit RGB colour. The core clock runs at twice the master pixel rate. An input pixel arrives on at most every other clock, marked by `in_valid`. An output pixel leaves on every clock while a line is being shown. A line therefore takes `2*LINE_PIX` clocks to arrive and `LINE_PIX` clocks to leave, so each stored line fits exactly twice into the time the next one takes to arrive.

Two line banks alternate. The line now arriving is packed into one bank while the line before it is read twice from the other. Every aligned group of four input pixels becomes a 4-bit colour code. That code passes through a fixed 16-entry palette, and the resulting colour is held for four output pixels.

Both streams are rigid video timing, so there is no back-pressure in either direction. There is no ready signal. The source must present pixels at its fixed rate, and the sink must accept a pixel on every clock in which `out_valid` is high.

Top module: `line_doubler`

## Requirements
- R1: The banks swap at every falling edge of `in_hsync`. The line captured between two consecutive falling edges is shown starting at the later of them. Lines appear at the output in arrival order.
- R2: Each captured line is emitted twice, back to back. Each copy is exactly `LINE_PIX` pixels long, and those pixels occupy consecutive clocks with `out_valid` high.
- R3: An input pixel is taken in each clock in which `in_valid` is high. The clock in which `in_hsync` is first seen low restarts the count, and a pixel taken in that same clock is pixel 0 of the new line.
- R4: Input pixels 4g to 4g+3 of a line form code g, and the earliest of the four lands in bit 3. Output pixel x of each copy shows code x/4, rounded down.
- R5: Codes 0 to 15 map to these RGB values (4 bits each for R, G, B): 000, 823, 52A, D4E, 075, 777, 29F, AAF, 550, F60, 888, FAB, 1D1, DD2, 4FA, FFF. Code 0 is black and code 15 is white.
- R6: `out_hsync` is high for the first `HS_OUT` pixels of each output line and low for the rest. While it is high, `out_rgb` is 0.
- R7: `out_vsync` equals the `in_vsync` value sampled at the `in_hsync` falling edge that began the line being shown. It holds that value over both copies.
- R8: After reset, and at any time no line is being shown, `out_valid`, `out_hsync`, `out_vsync` and `out_rgb` are all 0. Nothing is shown until two `in_hsync` falling edges have been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the input pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this clock |
| in_pix | input | 1 | Input pixel bit |
| in_hsync | input | 1 | Input horizontal sync, high during sync |
| in_vsync | input | 1 | Input vertical sync, high during sync |
| out_valid | output | 1 | Output pixel present this clock |
| out_rgb | output | 12 | Output colour, R in [11:8], G in [7:4], B in [3:0] |
| out_hsync | output | 1 | Regenerated horizontal sync at the doubled rate |
| out_vsync | output | 1 | Regenerated vertical sync, whole output lines |

## Verification
A bank select that fails to toggle shows up within a single output line. The same bank is then read while it is being written, so a copy mixes the old line with the new one, or the wrong line appears in order. A pixel counter or shift register that drifts out of phase places colour boundaries off 4-pixel multiples, or gives codes with shifted bits; this is seen on the first group of the affected line. A read counter that wraps at the wrong point changes the copy length or breaks the continuity of `out_valid`, and this is visible at the very next output line start.

// File: rtl/ld_pkg.sv
package ld_pkg;
  localparam int CODE_W = 4;
  localparam int CH_W   = 4;
  localparam int RGB_W  = 3 * CH_W;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [RGB_W-1:0]  rgb_t;

  // Fixed 16-entry colour map: 0 is black, 15 is white.
  function automatic rgb_t palette(code_t c);
    rgb_t r;
    case (c)
      4'd0:  r = 12'h000;
      4'd1:  r = 12'h823;
      4'd2:  r = 12'h52A;
      4'd3:  r = 12'hD4E;
      4'd4:  r = 12'h075;
      4'd5:  r = 12'h777;
      4'd6:  r = 12'h29F;
      4'd7:  r = 12'hAAF;
      4'd8:  r = 12'h550;
      4'd9:  r = 12'hF60;
      4'd10: r = 12'h888;
      4'd11: r = 12'hFAB;
      4'd12: r = 12'h1D1;
      4'd13: r = 12'hDD2;
      4'd14: r = 12'h4FA;
      default: r = 12'hFFF;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ld_capture.sv
module ld_capture
  import ld_pkg::*;
#(
  parameter int LINE_PIX = 912,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_pix,
  input  logic          in_hsync,
  input  logic          in_vsync,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_addr,
  output code_t         wr_code,
  output logic          start,
  output logic          start_bank,
  output logic          start_vs,
  output logic          start_ok
);
  localparam int CW = $clog2(LINE_PIX + 1);

  logic          hs_q;
  logic          wsel;
  logic          seen;
  logic          vs_line;
  logic [CW-1:0] wcnt;
  logic [2:0]    sh;

  logic          fall;
  logic [CW-1:0] idx;
  logic          take;

  // Line boundary: sync seen low after being high.
  assign fall = hs_q & ~in_hsync;
  assign idx  = fall ? '0 : wcnt;
  assign take = in_valid && (idx < CW'(LINE_PIX));

  assign wr_bank = fall ? ~wsel : wsel;
  assign wr_en   = take && (idx[1:0] == 2'b11);
  assign wr_addr = AW'(idx >> 2);
  assign wr_code = {sh, in_pix};

  // The finished line lives in the bank being left.
  assign start      = fall;
  assign start_bank = wsel;
  assign start_vs   = vs_line;
  assign start_ok   = seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      wsel    <= 1'b0;
      seen    <= 1'b0;
      vs_line <= 1'b0;
      wcnt    <= '0;
      sh      <= '0;
    end else begin
      hs_q <= in_hsync;
      if (fall) begin
        wsel    <= ~wsel;
        seen    <= 1'b1;
        vs_line <= in_vsync;
      end
      if (take) begin
        sh   <= {sh[1:0], in_pix};
        wcnt <= idx + CW'(1);
      end else begin
        wcnt <= idx;
      end
    end
  end
endmodule

// File: rtl/ld_linebuf.sv
module ld_linebuf
  import ld_pkg::*;
#(
  parameter int GROUPS = 228,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  code_t         wr_code,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output code_t         rd_data
);
  code_t q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    code_t arr [GROUPS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) arr[wr_addr] <= wr_code;
    end
    assign q[b] = arr[rd_addr];
  end

  always_ff @(posedge clk) rd_data <= q[rd_bank];
endmodule

// File: rtl/ld_scan.sv
module ld_scan
  import ld_pkg::*;
#(
  parameter int LINE_PIX = 912,
  parameter int HS_OUT   = 64,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_bank,
  input  logic          start_vs,
  input  logic          start_ok,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  input  code_t         rd_data,
  output logic          out_valid,
  output rgb_t          out_rgb,
  output logic          out_hsync,
  output logic          out_vsync
);
  localparam int XW = $clog2(LINE_PIX);

  logic          run;
  logic          bank;
  logic          vs;
  logic          pass;
  logic [XW-1:0] rx;
  logic          s1_valid, s1_hs, s1_vs;

  assign rd_bank = bank;
  assign rd_addr = AW'(rx >> 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      bank <= 1'b0;
      vs   <= 1'b0;
      pass <= 1'b0;
      rx   <= '0;
    end else if (start && start_ok) begin
      run  <= 1'b1;
      bank <= start_bank;
      vs   <= start_vs;
      pass <= 1'b0;
      rx   <= '0;
    end else if (run) begin
      if (rx == XW'(LINE_PIX - 1)) begin
        rx   <= '0;
        pass <= 1'b1;
        if (pass) run <= 1'b0;
      end else begin
        rx <= rx + XW'(1);
      end
    end
  end

  // Two stages: buffer read, then palette and blanking.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_hs     <= 1'b0;
      s1_vs     <= 1'b0;
      out_valid <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_rgb   <= '0;
    end else begin
      s1_valid  <= run;
      s1_hs     <= run && (rx < XW'(HS_OUT));
      s1_vs     <= run && vs;
      out_valid <= s1_valid;
      out_hsync <= s1_hs;
      out_vsync <= s1_vs;
      out_rgb   <= (s1_valid && !s1_hs) ? palette(rd_data) : '0;
    end
  end
endmodule

// File: rtl/line_doubler.sv
module line_doubler
  import ld_pkg::*;
#(
  parameter int LINE_PIX = 912,
  parameter int HS_OUT   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_pix,
  input  logic        in_hsync,
  input  logic        in_vsync,
  output logic        out_valid,
  output logic [11:0] out_rgb,
  output logic        out_hsync,
  output logic        out_vsync
);
  localparam int GROUPS = LINE_PIX / CODE_W;
  localparam int AW     = $clog2(GROUPS);

  logic          wr_en, wr_bank;
  logic [AW-1:0] wr_addr, rd_addr;
  code_t         wr_code, rd_data;
  logic          start, start_bank, start_vs, start_ok;
  logic          rd_bank;

  ld_capture #(.LINE_PIX(LINE_PIX), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_pix(in_pix),
    .in_hsync(in_hsync), .in_vsync(in_vsync),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_code(wr_code),
    .start(start), .start_bank(start_bank), .start_vs(start_vs),
    .start_ok(start_ok)
  );

  ld_linebuf #(.GROUPS(GROUPS), .AW(AW)) u_buf (
    .clk(clk),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_code(wr_code),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  ld_scan #(.LINE_PIX(LINE_PIX), .HS_OUT(HS_OUT), .AW(AW)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_bank(start_bank), .start_vs(start_vs),
    .start_ok(start_ok),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_rgb(out_rgb),
    .out_hsync(out_hsync), .out_vsync(out_vsync)
  );
endmodule

// File: rtl/ld_checker.sv
module ld_checker #(
  parameter int LINE_PIX = 912,
  parameter int HS_OUT   = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic [11:0] out_rgb,
  input logic        out_hsync,
  input logic        out_vsync
);
  localparam int PW = $clog2(LINE_PIX + 1) + 1;

  logic [PW-1:0] pos;
  logic [PW-1:0] hs_run;
  logic          prev_hs, prev_valid, prev_vs;
  logic [11:0]   prev_rgb;
  logic          rise;

  assign rise = out_hsync && !prev_hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos        <= '0;
      hs_run     <= '0;
      prev_hs    <= 1'b0;
      prev_valid <= 1'b0;
      prev_vs    <= 1'b0;
      prev_rgb   <= '0;
    end else begin
      prev_hs    <= out_hsync;
      prev_valid <= out_valid;
      prev_vs    <= out_vsync;
      prev_rgb   <= out_rgb;
      hs_run     <= out_hsync ? hs_run + PW'(1) : '0;
      if (out_valid) pos <= rise ? PW'(1) : pos + PW'(1);
      else           pos <= '0;
    end
  end

  // R6
  p_hs_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_hsync |-> out_rgb == 12'h000);
  // R6
  p_hs_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_hsync |-> hs_run < PW'(HS_OUT));
  // R8
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_hsync && !out_vsync && out_rgb == 12'h000));
  // R4
  p_group_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_valid && !rise && !out_hsync && pos[1:0] != 2'b00)
      |-> out_rgb == prev_rgb);
  // R2
  p_line_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && prev_valid) |-> pos == PW'(LINE_PIX));
  // R7
  p_vs_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_valid && !rise) |-> out_vsync == prev_vs);
endmodule

bind line_doubler ld_checker #(.LINE_PIX(LINE_PIX), .HS_OUT(HS_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_rgb(out_rgb),
  .out_hsync(out_hsync), .out_vsync(out_vsync)
);

// File: tb/sim_line_doubler.sv
module sim_line_doubler;
  localparam int L    = 32;
  localparam int HS   = 8;
  localparam int HSI  = 4;
  localparam int N    = 6;
  localparam int VSL  = 3;
  localparam int MAXC = 2 * N * L + 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_pix = 1'b0, in_hsync = 1'b1, in_vsync = 1'b0;
  logic out_valid, out_hsync, out_vsync;
  logic [11:0] out_rgb;

  int checks = 0, failures = 0;
  int falls = 0, early = 0, n = 0, cyc = 0;
  logic last_hs = 1'b1;
  logic [11:0] cap_rgb [MAXC];
  logic        cap_hs  [MAXC];
  logic        cap_vs  [MAXC];
  int          cap_t   [MAXC];

  always #2 clk = ~clk;

  line_doubler #(.LINE_PIX(L), .HS_OUT(HS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_hsync(in_hsync), .in_vsync(in_vsync), .out_valid(out_valid),
    .out_rgb(out_rgb), .out_hsync(out_hsync), .out_vsync(out_vsync)
  );

  function automatic logic [3:0] code_of(int i, int g);
    return 4'((i * 5 + g * 3 + i * g) % 16);
  endfunction

  function automatic logic [11:0] pal(logic [3:0] c);
    logic [11:0] t [16] = '{12'h000, 12'h823, 12'h52A, 12'hD4E, 12'h075,
      12'h777, 12'h29F, 12'hAAF, 12'h550, 12'hF60, 12'h888, 12'hFAB,
      12'h1D1, 12'hDD2, 12'h4FA, 12'hFFF};
    return t[c];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(logic p, logic hs, logic vs);
    @(negedge clk);
    if (last_hs && !hs) falls++;
    last_hs  = hs;
    in_valid = 1'b1; in_pix = p; in_hsync = hs; in_vsync = vs;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && out_valid) begin
      if (falls < 2) early++;
      if (n < MAXC) begin
        cap_rgb[n] = out_rgb; cap_hs[n] = out_hsync;
        cap_vs[n] = out_vsync; cap_t[n] = cyc;
      end
      n++;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
    check(out_rgb == 12'h000, "R8 reset rgb", int'(out_rgb), 0);
    check(out_hsync == 1'b0, "R8 reset hsync", int'(out_hsync), 0);
    check(out_vsync == 1'b0, "R8 reset vsync", int'(out_vsync), 0);
    rst_n = 1'b1;
    repeat (4) slot(1'b0, 1'b1, 1'b0);
    for (int i = 0; i <= N; i++) begin
      for (int s = 0; s < L; s++) begin
        logic [3:0] c;
        c = (i < N) ? code_of(i, s / 4) : 4'd0;
        slot(c[3 - (s % 4)], (s >= L - HSI), (i == VSL));
      end
    end
    repeat (2 * L + 8) slot(1'b0, 1'b1, 1'b0);
    // R8: nothing before a full line was captured
    check(early == 0, "R8 early output", early, 0);
    // R2: two copies per captured line
    check(n == 2 * N * L, "R2 pixel count", n, 2 * N * L);
    for (int k = 0; k < 2 * N * L && k < n; k++) begin
      int j, x;
      logic ehs;
      logic [11:0] erg;
      j   = k / (2 * L);
      x   = k % L;
      ehs = (x < HS);
      erg = ehs ? 12'h000 : pal(code_of(j, x / 4));
      // R1 R3 R4 R5: line order, bit order, grouping, palette
      check(cap_rgb[k] == erg, "R1/R3/R4/R5 colour", int'(cap_rgb[k]), int'(erg));
      check(cap_hs[k] == ehs, "R6 hsync", int'(cap_hs[k]), int'(ehs));
      check(cap_vs[k] == (j == VSL), "R7 vsync", int'(cap_vs[k]), int'(j == VSL));
      if (k % (2 * L) != 0)
        check(cap_t[k] == cap_t[k - 1] + 1, "R2 continuity", cap_t[k] - cap_t[k - 1], 1);
    end
    finish_run();
  end
endmodule